// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This block gathers the interrupt causes of a FIFO-based UART and reduces them to one interrupt request line and a 6-bit identification code. The code names the highest-priority cause that is both pending and enabled. Software reads the code to decide which register to service next. The block also holds the sticky cause flags and clears each one on the register access that acknowledges it.

Some causes are level conditions taken straight from the FIFO fill levels: receive data above its trigger, and transmit data below its trigger. Others are latched from single-cycle event pulses: line errors, modem line changes, receive timeout, and the two enhanced-mode causes. The enhanced-mode causes are flow-control or character-match events at level 5 and handshake-line changes at level 6. The serial engine, the FIFOs and the character matchers sit outside and feed this unit.

An access strobe (`isrRead`, `lsrRead`, `msrRead`, `rhrRead`) acts at the rising clock edge at the end of the cycle in which it is high. The code and interrupt line are combinational from the held flags and the present level inputs.

Top module: `uart_irq_ident`

## Requirements
- R1: While `rstN` is low, and directly after it, `irqCode` is 6'b000001, `irqOut` is 0, and `lineFlags` and `modemFlags` are 0.
- R2: `irqOut` is 1 exactly when `irqCode` differs from 6'b000001; bit 0 of the code is 1 only when nothing is reported.
- R3: A high bit of `rxErrEvt` sets the same bit of `lineFlags`. Bit 0 is overrun, bit 1 parity, bit 2 framing and bit 3 break. The flags clear on `lsrRead`, but an event in that same cycle is kept. Any set flag with `intEnable[2]` reports 6'b000110.
- R4: With `intEnable[0]`, `rxLevel > rxTrig` reports 6'b000100; equality does not.
- R5: A `timeoutEvt` pulse latches a timeout cause. It reports 6'b000100's neighbour code 6'b001100 under `intEnable[0]` and clears on `rhrRead`; a pulse in the same cycle wins.
- R6: The transmit cause latches when the below-trigger condition becomes true. Normally that condition is `txLevel < txTrig`. It reports 6'b000010 under `intEnable[1]`.
- R7: The transmit cause clears when the condition goes false, for example when writes push the level up to the trigger. It also clears when `isrRead` is high while 6'b000010 is the reported code. A read that reports any other code leaves it pending.
- R8: With `txExtTrig` high and `txTrig` zero, the condition is `txLevel == 0 && txShiftEmpty && txLineIdle`. With `txExtTrig` low, a zero trigger never raises it.
- R9: A high bit of `modemEvt` sets `modemFlags`; `msrRead` clears them. Any set flag with `intEnable[3]` reports 6'b000000.
- R10: A `lvl5Evt` pulse latches a level-5 cause. It reports 6'b010000 only when `enhMode` and `intEnable[4]` are both high. It clears on `isrRead` while that code is reported.
- R11: A `lvl6Evt` pulse latches a level-6 cause. It reports 6'b100000 only when `enhMode` and `intEnable[5]` are both high. It clears on `isrRead` while that code is reported.
- R12: Priority from highest is: line status, receive data, timeout, transmit, modem, level 5, level 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLevel | input | LVL_W | Receive FIFO fill level |
| rxTrig | input | LVL_W | Receive trigger threshold |
| txLevel | input | LVL_W | Transmit FIFO fill level |
| txTrig | input | LVL_W | Transmit trigger threshold |
| txExtTrig | input | 1 | Extended trigger levels in use |
| txShiftEmpty | input | 1 | Transmit shift register empty |
| txLineIdle | input | 1 | Serial output back at idle mark |
| rxErrEvt | input | 4 | Line error event pulses |
| modemEvt | input | 4 | Modem line change event pulses |
| timeoutEvt | input | 1 | Receive timeout event pulse |
| lvl5Evt | input | 1 | Flow-control / character-match event pulse |
| lvl6Evt | input | 1 | Handshake line change event pulse |
| intEnable | input | 6 | Per-cause enable mask |
| enhMode | input | 1 | Enhanced mode enabled |
| isrRead | input | 1 | Identification register read strobe |
| lsrRead | input | 1 | Line status read strobe |
| msrRead | input | 1 | Modem status read strobe |
| rhrRead | input | 1 | Receive holding register read strobe |
| irqCode | output | 6 | Identification code |
| irqOut | output | 1 | Combined interrupt request |
| lineFlags | output | 4 | Sticky line error flags |
| modemFlags | output | 4 | Sticky modem change flags |

## Verification
The bench targets an identification read that happens while a higher cause hides a pending transmit cause. A design that clears the hidden cause would lose the transmit interrupt once the higher cause drops. It also targets an acknowledge that coincides with a new event, where a design that lets the clear win would drop a line error. Other targets are the receive level exactly equal to its trigger, which a wrong comparison would report, and enhanced-mode causes raised with the mode off, which must stay latent and not leak or vanish. The zero-trigger rule is walked input by input, so a design that skips the shift-register or idle-line term fires early.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam logic [5:0] CODE_NONE  = 6'b000001;
  localparam logic [5:0] CODE_LINE  = 6'b000110;
  localparam logic [5:0] CODE_RXD   = 6'b000100;
  localparam logic [5:0] CODE_TOUT  = 6'b001100;
  localparam logic [5:0] CODE_TX    = 6'b000010;
  localparam logic [5:0] CODE_MODEM = 6'b000000;
  localparam logic [5:0] CODE_LVL5  = 6'b010000;
  localparam logic [5:0] CODE_LVL6  = 6'b100000;

  // clear strobes from control to datapath
  typedef struct packed {
    logic line;
    logic modem;
    logic timeout;
    logic tx;
    logic lvl5;
    logic lvl6;
  } clrStrobe_t;

  // raw (unmasked) cause state from datapath to control
  typedef struct packed {
    logic [3:0] line;
    logic [3:0] modem;
    logic       rxAbove;
    logic       timeout;
    logic       tx;
    logic       lvl5;
    logic       lvl6;
  } causeState_t;

endpackage

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] rxTrig,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] txTrig,
  input  logic             txExtTrig,
  input  logic             txShiftEmpty,
  input  logic             txLineIdle,
  input  logic [3:0]       rxErrEvt,
  input  logic [3:0]       modemEvt,
  input  logic             timeoutEvt,
  input  logic             lvl5Evt,
  input  logic             lvl6Evt,
  input  clrStrobe_t       clr,
  output causeState_t      cause
);

  logic [3:0] lineQ, modemQ;
  logic       toutQ, txQ, txCondQ, lvl5Q, lvl6Q;
  logic       txCond;
  logic       zeroTrigMode;

  assign zeroTrigMode = txExtTrig && (txTrig == '0);
  assign txCond = zeroTrigMode ? ((txLevel == '0) && txShiftEmpty && txLineIdle)
                               : (txLevel < txTrig);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ   <= '0;
      modemQ  <= '0;
      toutQ   <= 1'b0;
      txQ     <= 1'b0;
      txCondQ <= 1'b0;
      lvl5Q   <= 1'b0;
      lvl6Q   <= 1'b0;
    end else begin
      lineQ   <= (clr.line  ? 4'b0 : lineQ)  | rxErrEvt;
      modemQ  <= (clr.modem ? 4'b0 : modemQ) | modemEvt;
      toutQ   <= timeoutEvt | (toutQ & ~clr.timeout);
      lvl5Q   <= lvl5Evt    | (lvl5Q & ~clr.lvl5);
      lvl6Q   <= lvl6Evt    | (lvl6Q & ~clr.lvl6);
      txCondQ <= txCond;
      if (!txCond)       txQ <= 1'b0;
      else if (!txCondQ) txQ <= 1'b1;
      else if (clr.tx)   txQ <= 1'b0;
    end
  end

  always_comb begin
    cause.line    = lineQ;
    cause.modem   = modemQ;
    cause.rxAbove = rxLevel > rxTrig;
    cause.timeout = toutQ;
    cause.tx      = txQ;
    cause.lvl5    = lvl5Q;
    cause.lvl6    = lvl6Q;
  end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  causeState_t cause,
  input  logic [5:0]  intEnable,
  input  logic        enhMode,
  input  logic        isrRead,
  input  logic        lsrRead,
  input  logic        msrRead,
  input  logic        rhrRead,
  output clrStrobe_t  clr,
  output logic [5:0]  irqCode,
  output logic        irqOut
);

  localparam int NUM_LVL = 7;

  logic [NUM_LVL-1:0] active;   // index 0 is the highest priority
  logic [5:0]         codeTab [NUM_LVL];

  assign codeTab[0] = CODE_LINE;
  assign codeTab[1] = CODE_RXD;
  assign codeTab[2] = CODE_TOUT;
  assign codeTab[3] = CODE_TX;
  assign codeTab[4] = CODE_MODEM;
  assign codeTab[5] = CODE_LVL5;
  assign codeTab[6] = CODE_LVL6;

  always_comb begin
    active[0] = intEnable[2] && (|cause.line);
    active[1] = intEnable[0] && cause.rxAbove;
    active[2] = intEnable[0] && cause.timeout;
    active[3] = intEnable[1] && cause.tx;
    active[4] = intEnable[3] && (|cause.modem);
    active[5] = enhMode && intEnable[4] && cause.lvl5;
    active[6] = enhMode && intEnable[5] && cause.lvl6;
  end

  always_comb begin
    irqCode = CODE_NONE;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (active[i]) irqCode = codeTab[i];
    end
  end

  assign irqOut = |active;

  always_comb begin
    clr.line    = lsrRead;
    clr.modem   = msrRead;
    clr.timeout = rhrRead;
    clr.tx      = isrRead && (irqCode == CODE_TX);
    clr.lvl5    = isrRead && (irqCode == CODE_LVL5);
    clr.lvl6    = isrRead && (irqCode == CODE_LVL6);
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] rxTrig,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] txTrig,
  input  logic             txExtTrig,
  input  logic             txShiftEmpty,
  input  logic             txLineIdle,
  input  logic [3:0]       rxErrEvt,
  input  logic [3:0]       modemEvt,
  input  logic             timeoutEvt,
  input  logic             lvl5Evt,
  input  logic             lvl6Evt,
  input  logic [5:0]       intEnable,
  input  logic             enhMode,
  input  logic             isrRead,
  input  logic             lsrRead,
  input  logic             msrRead,
  input  logic             rhrRead,
  output logic [5:0]       irqCode,
  output logic             irqOut,
  output logic [3:0]       lineFlags,
  output logic [3:0]       modemFlags
);

  clrStrobe_t  clrStb;
  causeState_t causeSt;

  uart_irq_dp #(.LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .rxLevel(rxLevel), .rxTrig(rxTrig), .txLevel(txLevel), .txTrig(txTrig),
    .txExtTrig(txExtTrig), .txShiftEmpty(txShiftEmpty), .txLineIdle(txLineIdle),
    .rxErrEvt(rxErrEvt), .modemEvt(modemEvt), .timeoutEvt(timeoutEvt),
    .lvl5Evt(lvl5Evt), .lvl6Evt(lvl6Evt),
    .clr(clrStb), .cause(causeSt)
  );

  uart_irq_ctrl u_ctrl (
    .cause(causeSt), .intEnable(intEnable), .enhMode(enhMode),
    .isrRead(isrRead), .lsrRead(lsrRead), .msrRead(msrRead), .rhrRead(rhrRead),
    .clr(clrStb), .irqCode(irqCode), .irqOut(irqOut)
  );

  assign lineFlags  = causeSt.line;
  assign modemFlags = causeSt.modem;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [LVL_W-1:0] rxLevel,
  input logic [LVL_W-1:0] rxTrig,
  input logic [3:0]       rxErrEvt,
  input logic [3:0]       modemEvt,
  input logic [5:0]       intEnable,
  input logic             enhMode,
  input logic             lsrRead,
  input logic             msrRead,
  input logic [5:0]       irqCode,
  input logic             irqOut,
  input logic [3:0]       lineFlags,
  input logic [3:0]       modemFlags
);

  a_r2_idle_code: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (irqCode != 6'b000001));

  a_r3_lsr_clear: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead && rxErrEvt == 4'b0) |=> (lineFlags == 4'b0));

  a_r9_msr_clear: assert property (@(posedge clk) disable iff (!rstN)
    (msrRead && modemEvt == 4'b0) |=> (modemFlags == 4'b0));

  a_r12_line_first: assert property (@(posedge clk) disable iff (!rstN)
    ((|lineFlags) && intEnable[2]) |-> (irqCode == 6'b000110));

  a_r4_rx_second: assert property (@(posedge clk) disable iff (!rstN)
    ((rxLevel > rxTrig) && intEnable[0] && !((|lineFlags) && intEnable[2]))
      |-> (irqCode == 6'b000100));

  a_r10_enh_gate: assert property (@(posedge clk) disable iff (!rstN)
    !enhMode |-> (irqCode != 6'b010000 && irqCode != 6'b100000));

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .rxLevel(rxLevel), .rxTrig(rxTrig),
  .rxErrEvt(rxErrEvt), .modemEvt(modemEvt), .intEnable(intEnable),
  .enhMode(enhMode), .lsrRead(lsrRead), .msrRead(msrRead),
  .irqCode(irqCode), .irqOut(irqOut), .lineFlags(lineFlags),
  .modemFlags(modemFlags)
);

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;

  localparam int LVL_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LVL_W-1:0] rxLevel = '0, rxTrig = 5'd8, txLevel = '0, txTrig = 5'd4;
  logic txExtTrig = 1'b0, txShiftEmpty = 1'b1, txLineIdle = 1'b1;
  logic [3:0] rxErrEvt = '0, modemEvt = '0;
  logic timeoutEvt = 1'b0, lvl5Evt = 1'b0, lvl6Evt = 1'b0;
  logic [5:0] intEnable = '0;
  logic enhMode = 1'b0;
  logic isrRead = 1'b0, lsrRead = 1'b0, msrRead = 1'b0, rhrRead = 1'b0;
  logic [5:0] irqCode;
  logic irqOut;
  logic [3:0] lineFlags, modemFlags;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rstN(rstN), .rxLevel(rxLevel), .rxTrig(rxTrig),
    .txLevel(txLevel), .txTrig(txTrig), .txExtTrig(txExtTrig),
    .txShiftEmpty(txShiftEmpty), .txLineIdle(txLineIdle),
    .rxErrEvt(rxErrEvt), .modemEvt(modemEvt), .timeoutEvt(timeoutEvt),
    .lvl5Evt(lvl5Evt), .lvl6Evt(lvl6Evt), .intEnable(intEnable),
    .enhMode(enhMode), .isrRead(isrRead), .lsrRead(lsrRead),
    .msrRead(msrRead), .rhrRead(rhrRead), .irqCode(irqCode),
    .irqOut(irqOut), .lineFlags(lineFlags), .modemFlags(modemFlags)
  );

  // reference model state
  logic [3:0] mLine = '0, mModem = '0;
  logic mTout = 1'b0, mTx = 1'b0, mTxPrev = 1'b0, mL5 = 1'b0, mL6 = 1'b0;

  function automatic logic [5:0] expCode();
    if (intEnable[2] && mLine != 0)            return 6'b000110;
    if (intEnable[0] && rxLevel > rxTrig)      return 6'b000100;
    if (intEnable[0] && mTout)                 return 6'b001100;
    if (intEnable[1] && mTx)                   return 6'b000010;
    if (intEnable[3] && mModem != 0)           return 6'b000000;
    if (enhMode && intEnable[4] && mL5)        return 6'b010000;
    if (enhMode && intEnable[5] && mL6)        return 6'b100000;
    return 6'b000001;
  endfunction

  function automatic logic txBelow();
    if (txExtTrig && txTrig == 0)
      return (txLevel == 0) && txShiftEmpty && txLineIdle;
    return int'(txLevel) < int'(txTrig);
  endfunction

  always @(posedge clk) begin
    logic [5:0] shown;
    logic below;
    cycles++;
    if (!rstN) begin
      mLine = '0; mModem = '0; mTout = 0; mTx = 0; mTxPrev = 0; mL5 = 0; mL6 = 0;
    end else begin
      shown = expCode();
      below = txBelow();
      mLine  = (lsrRead ? 4'b0 : mLine) | rxErrEvt;
      mModem = (msrRead ? 4'b0 : mModem) | modemEvt;
      if (timeoutEvt) mTout = 1; else if (rhrRead) mTout = 0;
      if (lvl5Evt) mL5 = 1; else if (isrRead && shown == 6'b010000) mL5 = 0;
      if (lvl6Evt) mL6 = 1; else if (isrRead && shown == 6'b100000) mL6 = 0;
      if (!below) mTx = 0;
      else if (!mTxPrev) mTx = 1;
      else if (isrRead && shown == 6'b000010) mTx = 0;
      mTxPrev = below;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    checks++;
    if (irqCode !== expCode() || irqOut !== (expCode() != 6'b000001) ||
        lineFlags !== mLine || modemFlags !== mModem) begin
      errors++;
      $display("FAIL R12 cycle %0d: code=%b irq=%b line=%b modem=%b exp code=%b line=%b modem=%b",
               cycles, irqCode, irqOut, lineFlags, modemFlags, expCode(), mLine, mModem);
    end
  end

  task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    rxErrEvt = '0; modemEvt = '0; timeoutEvt = 0; lvl5Evt = 0; lvl6Evt = 0;
    isrRead = 0; lsrRead = 0; msrRead = 0; rhrRead = 0;
    #1;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) cyc();
    chk("R1 reset code", irqCode, 6'b000001);
    chk("R1 reset irq", {5'b0, irqOut}, 6'b0);
    chk("R1 reset flags", {2'b0, lineFlags}, 6'b0);
    rstN = 1;
    cyc();
    chk("R2 masked tx idle code", irqCode, 6'b000001);
    chk("R2 idle irq low", {5'b0, irqOut}, 6'b0);

    intEnable = 6'b000010; cyc();
    chk("R6 tx below trigger", irqCode, 6'b000010);
    chk("R2 irq high", {5'b0, irqOut}, 6'b1);
    isrRead = 1; cyc();
    chk("R7 isr read clears tx", irqCode, 6'b000001);
    txLevel = 5; cyc();
    txLevel = 2; cyc();
    chk("R6 tx re-armed on fall", irqCode, 6'b000010);
    txLevel = 6; cyc();
    chk("R7 tx cleared by level", irqCode, 6'b000001);

    intEnable = 6'b000011; rxLevel = 8; cyc();
    chk("R4 equal level not above", irqCode, 6'b000001);
    rxLevel = 9; cyc();
    chk("R4 rx above trigger", irqCode, 6'b000100);
    timeoutEvt = 1; cyc();
    chk("R12 rx over timeout", irqCode, 6'b000100);
    rxLevel = 0; cyc();
    chk("R5 timeout shown", irqCode, 6'b001100);
    intEnable = 6'b000010; cyc();
    chk("R5 timeout masked", irqCode, 6'b000001);
    intEnable = 6'b000011; rhrRead = 1; cyc();
    chk("R5 rhr read clears timeout", irqCode, 6'b000001);

    rxErrEvt = 4'b0100; cyc();
    chk("R3 flag latched", {2'b0, lineFlags}, 6'b000100);
    chk("R3 masked line", irqCode, 6'b000001);
    intEnable = 6'b000111; rxLevel = 9; cyc();
    chk("R12 line over rx", irqCode, 6'b000110);
    lsrRead = 1; cyc();
    chk("R3 lsr clears", {2'b0, lineFlags}, 6'b0);
    chk("R3 rx after clear", irqCode, 6'b000100);
    rxErrEvt = 4'b0001; lsrRead = 1; cyc();
    chk("R3 event kept over clear", {2'b0, lineFlags}, 6'b000001);
    lsrRead = 1; cyc();

    intEnable = 6'b001111; modemEvt = 4'b1000; cyc();
    chk("R12 rx over modem", irqCode, 6'b000100);
    rxLevel = 0; cyc();
    chk("R9 modem shown", irqCode, 6'b000000);
    chk("R9 modem irq", {5'b0, irqOut}, 6'b1);
    chk("R9 modem flags", {2'b0, modemFlags}, 6'b001000);
    msrRead = 1; cyc();
    chk("R9 msr clears", irqCode, 6'b000001);

    txLevel = 2; cyc();
    chk("R6 tx again", irqCode, 6'b000010);
    rxLevel = 9; cyc();
    isrRead = 1; cyc();
    chk("R7 hidden read keeps rx", irqCode, 6'b000100);
    rxLevel = 0; cyc();
    chk("R7 hidden tx survives", irqCode, 6'b000010);
    isrRead = 1; cyc();
    chk("R7 cleared when shown", irqCode, 6'b000001);

    intEnable = 6'b111111; lvl5Evt = 1; cyc();
    chk("R10 gated without enhanced", irqCode, 6'b000001);
    isrRead = 1; cyc();
    enhMode = 1; cyc();
    chk("R10 latent level5 appears", irqCode, 6'b010000);
    lvl6Evt = 1; cyc();
    chk("R12 level5 over level6", irqCode, 6'b010000);
    isrRead = 1; cyc();
    chk("R11 level6 after level5 read", irqCode, 6'b100000);
    isrRead = 1; cyc();
    chk("R11 level6 cleared", irqCode, 6'b000001);
    enhMode = 0; lvl6Evt = 1; cyc();
    chk("R11 gated without enhanced", irqCode, 6'b000001);
    enhMode = 1; cyc();
    chk("R11 level6 code", irqCode, 6'b100000);
    isrRead = 1; cyc();

    txLevel = 6; cyc();
    txExtTrig = 1; txTrig = 0; txLevel = 0; txShiftEmpty = 0; cyc();
    chk("R8 shift busy", irqCode, 6'b000001);
    txShiftEmpty = 1; txLineIdle = 0; cyc();
    chk("R8 line not idle", irqCode, 6'b000001);
    txLineIdle = 1; cyc();
    chk("R8 all idle", irqCode, 6'b000010);
    isrRead = 1; cyc();
    txExtTrig = 0; txLevel = 6; cyc();
    txLevel = 0; cyc();
    chk("R8 zero trigger without extension", irqCode, 6'b000001);

    repeat (2) cyc();
    finishRun();
  end

endmodule